// File: doc/BRIEF.md
# Control Register Access Permission Checker

This block decides whether one access to a 12-bit control-register address is allowed. A caller gives the address, the current operating mode, whether the access writes, and whether the machine runs with 64-bit words. One cycle later the block returns a single illegal flag and a 3-bit reason code. Most of the rules come from bit fields of the address itself. The top two address bits mark a register as read-only. The next two bits give the lowest mode allowed to reach it.

Two address ranges get their own rules. One range can be reached only from the debug mode. The other holds the upper halves of the 64-bit counters, and it exists only in a 32-bit configuration. The set of addresses that exist is a parameterised list of inclusive windows inside the checker. The block stores no register contents.

The request side has a valid qualifier and no ready signal. The block accepts a request on every cycle, so it never applies back-pressure. Each request accepted at a clock edge produces exactly one result, marked by rsp_valid on the following cycle. Result fields hold their last value while rsp_valid is low.

Top module: `csr_perm_check`

## Requirements
- R1: While rst_n is low, and after it is released until the first request, rsp_valid and rsp_illegal are 0 and rsp_cause is 0.
- R2: A request presented with req_valid=1 at a rising edge produces rsp_valid=1 for exactly the next cycle. rsp_cause and rsp_illegal in that cycle belong to that request. A cycle without req_valid gives rsp_valid=0 one cycle later.
- R3: An address outside every default window gives cause 1 (unimplemented). The default windows are 0x001-0x003, 0x100-0x180, 0x300-0x3FF, 0x600-0x6FF, 0x7A0-0x7BF, 0xB00-0xB9F, 0xC00-0xC9F and 0xF11-0xF15.
- R4: req_mode codes are 00 user (rank 0), 01 supervisor (rank 1), 11 machine (rank 3) and 10 debug (rank 4). If the rank is below address bits [9:8], read as a number, the result is cause 2 (privilege).
- R5: In any mode other than debug, an access to 0x7B0-0x7BF gives cause 3 (debug-only). In machine mode, 0x7A0-0x7AF is a legal read/write range.
- R6: A write (req_write=1) to an address whose bits [11:10] are 11 gives cause 4 (read-only write). A read of such an address at sufficient rank is legal.
- R7: With req_xlen64=1, an access to 0xC80-0xC9F or 0xB80-0xB9F gives cause 5 (high half). With req_xlen64=0, these addresses are legal, subject to the other rules.
- R8: When several rules fail, the reported cause is the first failing rule in this order: unimplemented (1), privilege (2), debug-only (3), read-only write (4), high half (5).
- R9: Debug mode passes the privilege and debug-only rules for every implemented address. The read-only write rule and the high-half rule still apply.
- R10: rsp_illegal is 1 exactly when rsp_cause is not 0, and cause 0 means the access is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | Register address |
| req_mode | input | 2 | Current mode: 00 user, 01 supervisor, 11 machine, 10 debug |
| req_write | input | 1 | 1 when the access writes |
| req_xlen64 | input | 1 | 1 for a 64-bit word configuration |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_illegal | output | 1 | Access must raise an illegal-instruction trap |
| rsp_cause | output | 3 | Reason code, 0 means legal |

## Verification
Every result is due exactly one cycle after the edge that accepts its request, and the block has no other latency path. The driver applies a request on a falling edge and pushes its expected code into a queue. The monitor, also on falling edges, pops one entry whenever rsp_valid is high and compares it against the result. This puts each sample half a cycle after the register that produced it, and a result that comes too early, too late or without a request shows up as a queue mismatch. Back-to-back requests across the whole address space, in every mode, direction and word width, check that results stay in step cycle after cycle.

// File: rtl/csr_perm_pkg.sv
package csr_perm_pkg;
  localparam int ADDR_W = 12;

  typedef enum logic [1:0] {
    MODE_USER    = 2'b00,
    MODE_SUPER   = 2'b01,
    MODE_DEBUG   = 2'b10,
    MODE_MACHINE = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_UNIMPL  = 3'd1,
    CAUSE_PRIV    = 3'd2,
    CAUSE_DBGONLY = 3'd3,
    CAUSE_ROWRITE = 3'd4,
    CAUSE_HIHALF  = 3'd5
  } cause_e;

  localparam logic [ADDR_W-1:0] DBG_ONLY_LO = 12'h7B0;
  localparam logic [ADDR_W-1:0] DBG_ONLY_HI = 12'h7BF;
  localparam logic [ADDR_W-1:0] HH_USER_LO  = 12'hC80;
  localparam logic [ADDR_W-1:0] HH_USER_HI  = 12'hC9F;
  localparam logic [ADDR_W-1:0] HH_MACH_LO  = 12'hB80;
  localparam logic [ADDR_W-1:0] HH_MACH_HI  = 12'hB9F;

  // Rank of a mode; debug sits above machine.
  function automatic logic [2:0] mode_rank(input logic [1:0] m);
    case (m)
      2'b00:   return 3'd0;
      2'b01:   return 3'd1;
      2'b11:   return 3'd3;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/csr_impl_table.sv
module csr_impl_table #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned N_WIN  = 8,
  parameter logic [N_WIN*ADDR_W-1:0] WIN_LO = '0,
  parameter logic [N_WIN*ADDR_W-1:0] WIN_HI = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              implemented
);
  logic [N_WIN-1:0] win_hit;

  for (genvar gi = 0; gi < N_WIN; gi++) begin : g_win
    assign win_hit[gi] = (addr >= WIN_LO[gi*ADDR_W +: ADDR_W]) &&
                         (addr <= WIN_HI[gi*ADDR_W +: ADDR_W]);
  end

  assign implemented = |win_hit;
endmodule

// File: rtl/csr_field_decode.sv
module csr_field_decode #(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] DBG_LO  = 12'h7B0,
  parameter logic [ADDR_W-1:0] DBG_HI  = 12'h7BF,
  parameter logic [ADDR_W-1:0] HHU_LO  = 12'hC80,
  parameter logic [ADDR_W-1:0] HHU_HI  = 12'hC9F,
  parameter logic [ADDR_W-1:0] HHM_LO  = 12'hB80,
  parameter logic [ADDR_W-1:0] HHM_HI  = 12'hB9F
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        mode,
  output logic              read_only,
  output logic              rank_short,
  output logic              dbg_range,
  output logic              high_half
);
  localparam int unsigned TOP = ADDR_W - 1;
  logic [2:0] rank;
  logic [2:0] need;

  assign rank       = csr_perm_pkg::mode_rank(mode);
  assign need       = {1'b0, addr[TOP-2 -: 2]};
  assign read_only  = &addr[TOP -: 2];
  assign rank_short = rank < need;
  assign dbg_range  = (addr >= DBG_LO) && (addr <= DBG_HI);
  assign high_half  = ((addr >= HHU_LO) && (addr <= HHU_HI)) ||
                      ((addr >= HHM_LO) && (addr <= HHM_HI));
endmodule

// File: rtl/csr_cause_prio.sv
module csr_cause_prio
  import csr_perm_pkg::*;
(
  input  logic   unimpl,
  input  logic   rank_short,
  input  logic   dbg_block,
  input  logic   ro_write,
  input  logic   hh_block,
  output cause_e cause
);
  always_comb begin
    if (unimpl)          cause = CAUSE_UNIMPL;
    else if (rank_short) cause = CAUSE_PRIV;
    else if (dbg_block)  cause = CAUSE_DBGONLY;
    else if (ro_write)   cause = CAUSE_ROWRITE;
    else if (hh_block)   cause = CAUSE_HIHALF;
    else                 cause = CAUSE_NONE;
  end
endmodule

// File: rtl/csr_perm_check.sv
module csr_perm_check
  import csr_perm_pkg::*;
#(
  parameter int unsigned N_WIN = 8,
  parameter logic [N_WIN*ADDR_W-1:0] IMPL_LO = {12'hF11, 12'hC00, 12'hB00, 12'h7A0,
                                                12'h600, 12'h300, 12'h100, 12'h001},
  parameter logic [N_WIN*ADDR_W-1:0] IMPL_HI = {12'hF15, 12'hC9F, 12'hB9F, 12'h7BF,
                                                12'h6FF, 12'h3FF, 12'h180, 12'h003}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [11:0] req_addr,
  input  logic [1:0]  req_mode,
  input  logic        req_write,
  input  logic        req_xlen64,
  output logic        rsp_valid,
  output logic        rsp_illegal,
  output logic [2:0]  rsp_cause
);
  logic   implemented;
  logic   read_only;
  logic   rank_short;
  logic   dbg_range;
  logic   high_half;
  logic   in_debug;
  cause_e cause_nxt;

  csr_impl_table #(
    .ADDR_W (ADDR_W),
    .N_WIN  (N_WIN),
    .WIN_LO (IMPL_LO),
    .WIN_HI (IMPL_HI)
  ) u_table (
    .addr        (req_addr),
    .implemented (implemented)
  );

  csr_field_decode #(
    .ADDR_W (ADDR_W),
    .DBG_LO (DBG_ONLY_LO),
    .DBG_HI (DBG_ONLY_HI),
    .HHU_LO (HH_USER_LO),
    .HHU_HI (HH_USER_HI),
    .HHM_LO (HH_MACH_LO),
    .HHM_HI (HH_MACH_HI)
  ) u_decode (
    .addr       (req_addr),
    .mode       (req_mode),
    .read_only  (read_only),
    .rank_short (rank_short),
    .dbg_range  (dbg_range),
    .high_half  (high_half)
  );

  assign in_debug = (req_mode == MODE_DEBUG);

  csr_cause_prio u_prio (
    .unimpl     (!implemented),
    .rank_short (rank_short),
    .dbg_block  (dbg_range && !in_debug),
    .ro_write   (read_only && req_write),
    .hh_block   (high_half && req_xlen64),
    .cause      (cause_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_cause   <= 3'd0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_cause   <= cause_nxt;
        rsp_illegal <= (cause_nxt != CAUSE_NONE);
      end
    end
  end
endmodule

// File: rtl/csr_perm_check_sva.sv
module csr_perm_check_sva
  import csr_perm_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [11:0] req_addr,
  input logic [1:0]  req_mode,
  input logic        req_write,
  input logic        req_xlen64,
  input logic        rsp_valid,
  input logic        rsp_illegal,
  input logic [2:0]  rsp_cause
);
  logic short_rank;
  logic dbg_hit;
  logic hh_hit;

  assign short_rank = mode_rank(req_mode) < {1'b0, req_addr[9:8]};
  assign dbg_hit    = (req_addr >= DBG_ONLY_LO) && (req_addr <= DBG_ONLY_HI);
  assign hh_hit     = ((req_addr >= HH_USER_LO) && (req_addr <= HH_USER_HI)) ||
                      ((req_addr >= HH_MACH_LO) && (req_addr <= HH_MACH_HI));

  assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

  assert_flag_matches_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_illegal == (rsp_cause != 3'd0)));

  assert_low_rank_illegal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && short_rank) |-> rsp_illegal);

  assert_machine_debug_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && dbg_hit && req_mode == MODE_MACHINE) |-> rsp_illegal);

  assert_ro_write_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_write && (&req_addr[11:10])) |-> rsp_illegal);

  assert_high_half_wide_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_xlen64 && hh_hit) |-> rsp_illegal);

  assert_debug_reads_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && dbg_hit && req_mode == MODE_DEBUG && !req_write) |-> !rsp_illegal);
endmodule

bind csr_perm_check csr_perm_check_sva i_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .req_mode    (req_mode),
  .req_write   (req_write),
  .req_xlen64  (req_xlen64),
  .rsp_valid   (rsp_valid),
  .rsp_illegal (rsp_illegal),
  .rsp_cause   (rsp_cause)
);

// File: tb/test_csr_perm_check.sv
module test_csr_perm_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_mode = '0;
  logic        req_write = 1'b0;
  logic        req_xlen64 = 1'b0;
  logic        rsp_valid;
  logic        rsp_illegal;
  logic [2:0]  rsp_cause;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  csr_perm_check i_csr_perm_check (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_mode    (req_mode),
    .req_write   (req_write),
    .req_xlen64  (req_xlen64),
    .rsp_valid   (rsp_valid),
    .rsp_illegal (rsp_illegal),
    .rsp_cause   (rsp_cause)
  );

  function automatic bit in_rng(input logic [11:0] a, input int lo, input int hi);
    return (int'(a) >= lo) && (int'(a) <= hi);
  endfunction

  // Expected cause from the requirements (R3..R9).
  function automatic logic [2:0] model(input logic [11:0] a, input logic [1:0] m,
                                       input logic w, input logic x64);
    int rank;
    bit impl;
    impl = in_rng(a, 'h001, 'h003) || in_rng(a, 'h100, 'h180) || in_rng(a, 'h300, 'h3FF) ||
           in_rng(a, 'h600, 'h6FF) || in_rng(a, 'h7A0, 'h7BF) || in_rng(a, 'hB00, 'hB9F) ||
           in_rng(a, 'hC00, 'hC9F) || in_rng(a, 'hF11, 'hF15);
    case (m)
      2'b00: rank = 0;
      2'b01: rank = 1;
      2'b11: rank = 3;
      default: rank = 4;
    endcase
    if (!impl) return 3'd1;
    if (rank < int'(a[9:8])) return 3'd2;
    if (in_rng(a, 'h7B0, 'h7BF) && m != 2'b10) return 3'd3;
    if (w && a[11:10] == 2'b11) return 3'd4;
    if (x64 && (in_rng(a, 'hC80, 'hC9F) || in_rng(a, 'hB80, 'hB9F))) return 3'd5;
    return 3'd0;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: one request per falling edge, expected value queued.
  task automatic send(input logic [11:0] a, input logic [1:0] m, input logic w,
                      input logic x64, input string tag);
    @(negedge clk);
    req_valid  = 1'b1;
    req_addr   = a;
    req_mode   = m;
    req_write  = w;
    req_xlen64 = x64;
    exp_q.push_back(model(a, m, w, x64));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compares each result half a cycle after it is registered.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected result", {7'd0, rsp_valid}, 8'd0);
      end else begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {5'd0, rsp_cause}, {5'd0, e});
        check("R10 flag", {7'd0, rsp_illegal}, {7'd0, (rsp_cause != 3'd0)});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {7'd0, rsp_valid}, 8'd0);
    check("R1 illegal in reset", {7'd0, rsp_illegal}, 8'd0);
    check("R1 cause in reset", {5'd0, rsp_cause}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 valid after reset", {7'd0, rsp_valid}, 8'd0);
    check("R1 cause after reset", {5'd0, rsp_cause}, 8'd0);

    // Directed corners
    send(12'h000, 2'b11, 1'b0, 1'b0, "R3 unimplemented 0x000");
    send(12'h7C0, 2'b10, 1'b0, 1'b0, "R3 unimplemented 0x7C0");
    send(12'h300, 2'b01, 1'b0, 1'b0, "R4 supervisor to machine reg");
    send(12'h100, 2'b00, 1'b0, 1'b0, "R4 user to supervisor reg");
    send(12'h600, 2'b01, 1'b0, 1'b0, "R4 supervisor to hyp reg");
    send(12'h600, 2'b11, 1'b1, 1'b0, "R4 machine to hyp reg ok");
    send(12'h7B0, 2'b11, 1'b0, 1'b0, "R5 machine to debug-only");
    send(12'h7A1, 2'b11, 1'b1, 1'b0, "R5 machine to 0x7A1 ok");
    send(12'hC00, 2'b00, 1'b1, 1'b0, "R6 write read-only");
    send(12'hC00, 2'b00, 1'b0, 1'b0, "R6 read read-only ok");
    send(12'hC80, 2'b00, 1'b0, 1'b1, "R7 high half on 64");
    send(12'hB85, 2'b11, 1'b1, 1'b0, "R7 high half on 32 ok");
    send(12'h7B3, 2'b00, 1'b1, 1'b0, "R8 priv before debug-only");
    send(12'hF12, 2'b01, 1'b1, 1'b0, "R8 priv before ro write");
    send(12'hC81, 2'b00, 1'b1, 1'b1, "R8 ro write before high half");
    send(12'h7B2, 2'b10, 1'b1, 1'b0, "R9 debug writes debug-only");
    send(12'hF11, 2'b10, 1'b1, 1'b0, "R9 debug ro write still illegal");
    send(12'hC90, 2'b10, 1'b0, 1'b1, "R9 debug high half still illegal");
    idle();
    @(negedge clk);
    check("R2 valid drops", {7'd0, rsp_valid}, 8'd0);

    // Exhaustive back-to-back sweep
    for (int a = 0; a < 4096; a++) begin
      for (int k = 0; k < 16; k++) begin
        send(a[11:0], k[1:0], k[2], k[3], "R8 sweep cause");
      end
    end
    idle();
    repeat (3) @(negedge clk);
    check("R2 queue drained", exp_q.size() == 0 ? 8'd1 : 8'd0, 8'd1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule